// File: doc/BRIEF.md
# Cycle Measurement Timer

This block is a 16-bit up-counter with a small register interface. It has two modes. In timer mode it offers compare match and input capture. In cycle measurement mode it measures the period of an external cycle signal: it counts between successive active edges of that signal.

The count clock comes from a prescaler, which divides the system clock by 2, 8, 16, 32, 64, 128 or 256. It can instead come from an external clock pin, counted on a selectable edge. Both the cycle input and the external clock pass through a two-flop synchronizer before their edges are detected.

The active edge of the cycle input is the XOR of an edge-select bit and a polarity bit. Software drives the block through word writes and combinational reads at five addresses.

Top module: `cycle_meas_timer`

Register map. Addresses and fields are as follows:
- 0, control: bit0 run, bit1 measure, bit2 edgeSel, bit3 polarity, bits 6:4 clkSel, bit7 extFall.
- 1, status: bit0 compare flag, bit1 capture flag, bit2 overflow flag.
- 2, counter.
- 3, compare.
- 4, capture (read-only).

## Requirements
- R1: After reset, the control, status, counter, compare and capture registers all read 0.
- R2: The clkSel field selects the prescaler divisor D: 000 gives 2, 001 gives 8, 010 gives 16, 011 gives 32, 100 gives 64, 101 gives 128, 110 gives 256. The prescaler is cleared while counting is off. Counting is on while run (bit0) or measure (bit1) is 1. N cycles after the write that turns counting on, the counter holds floor(N/D).
- R3: With clkSel = 111 the counter advances once per edge of the external clock. The edge is rising when extFall (bit7) is 0 and falling when it is 1. The counter changes 3 clock edges after the pin changes.
- R4: A control write changes clkSel only if run and measure were both 0 before the write. Otherwise the field keeps its old value, while the other control bits still update.
- R5: The active edge of the cycle input is rising when edgeSel XOR polarity is 0, and falling when it is 1. The other edge has no effect. An active edge that appears on the pin before clock edge E0 is acted on at clock edge E2.
- R6: In timer mode (measure = 0) an active edge copies the counter into the capture register and sets the capture flag (status bit1). It leaves the counter unchanged, whether or not run is set.
- R7: In timer mode with run = 1, the compare flag (status bit0) sets one cycle after the counter equals the compare register. It does not set while the counter differs.
- R8: Setting measure to 1 starts counting without run. Each active edge then copies the counter to capture, restarts the counter and sets the capture flag. A tick in the same cycle counts toward the new interval. For a cycle period of P clock cycles, where P is a multiple of D, the captured value is P/D.
- R9: In measure mode the overflow flag (status bit2) sets when the counter wraps from 0xFFFF to 0. A wrap in timer mode does not set it.
- R10: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged.
- R11: A write to the counter address loads the counter at any time, with priority over counting and restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr (combinational) |
| cycIn | input | 1 | External cycle input (asynchronous) |
| extClkIn | input | 1 | External count clock (asynchronous) |

## Verification
The prescaler is run at every divisor, and the count is sampled one cycle before and one cycle after its second tick, which separates an off-by-one in the divider from the wrong divisor. Timer-mode capture is driven with the four combinations of edge select and polarity, each followed by a lone rising edge and then a lone falling edge. This shows which edge each combination honours and also the synchronizer latency. Period measurement uses square waves of different period and divisor, so the captured count must track both. Overflow is provoked by preloading the counter near its top in each mode, which distinguishes a measure-only overflow from a plain wrap.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP  = 3'd4;

  localparam int B_RUN  = 0;
  localparam int B_MEAS = 1;
  localparam int B_EDGE = 2;
  localparam int B_POL  = 3;
  localparam int B_SEL  = 4;
  localparam int B_EXTF = 7;

  localparam int F_CMP = 0;
  localparam int F_CAP = 1;
  localparam int F_OVF = 2;

  localparam logic [SEL_W-1:0] SEL_EXT = 3'b111;

  typedef struct packed {
    logic tick;      // one-cycle count enable
    logic cntWr;     // software load of the counter
    logic cmpWr;     // software load of the compare register
    logic capEvt;    // active cycle-input edge
    logic clrOnCap;  // restart the counter on capture
  } dpStrobe_t;
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
  import cmt_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic [SEL_W-1:0] selQ,
  input  logic             extFall,
  input  logic             extClkIn,
  output logic             tick
);
  localparam int N_DIV = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre;
  logic             extS1, extS2, extPrev;
  logic             extHit;
  logic [N_DIV:0]   hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre     <= '0;
      extS1   <= 1'b0;
      extS2   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      pre     <= active ? pre + 1'b1 : '0;
      extS1   <= extClkIn;
      extS2   <= extS1;
      extPrev <= extS2;
    end
  end

  assign extHit = extFall ? (!extS2 && extPrev) : (extS2 && !extPrev);

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    localparam int K = (i == 0) ? 1 : i + 2;
    assign hitVec[i] = &pre[K-1:0];
  end
  assign hitVec[N_DIV] = extHit;

  assign tick = active && hitVec[selQ];

  // R2
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && selQ != SEL_EXT) |=> !tick);
  // R2
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (pre == '0));
endmodule

// File: rtl/cmt_datapath.sv
module cmt_datapath
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] compareQ,
  output logic [CNT_W-1:0] captureQ,
  output logic             cmpEq,
  output logic             wrapEvt
);
  logic             restart;
  logic [CNT_W-1:0] countNext;

  assign restart = strb.capEvt && strb.clrOnCap;

  always_comb begin
    countNext = countQ;
    if (strb.cntWr)      countNext = wrData;
    else if (restart)    countNext = strb.tick ? CNT_W'(1) : '0;
    else if (strb.tick)  countNext = countQ + 1'b1;
  end

  assign wrapEvt = strb.tick && (&countQ) && !strb.cntWr && !restart;
  assign cmpEq   = (countQ == compareQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      compareQ <= '0;
      captureQ <= '0;
    end else begin
      countQ <= countNext;
      if (strb.cmpWr)  compareQ <= wrData;
      if (strb.capEvt) captureQ <= countQ;
    end
  end

  // R8
  meas_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (restart && !strb.cntWr) |=> (countQ <= CNT_W'(1)));
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.cntWr && !strb.capEvt) |=> $stable(countQ));
  // R11
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntWr |=> (countQ == $past(wrData)));
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              cycIn,
  input  logic              tick,
  input  logic              cmpEq,
  input  logic              wrapEvt,
  input  logic [CNT_W-1:0]  countQ,
  input  logic [CNT_W-1:0]  compareQ,
  input  logic [CNT_W-1:0]  captureQ,
  output dpStrobe_t         strb,
  output logic [CNT_W-1:0]  rdData,
  output logic              active,
  output logic [SEL_W-1:0]  clkSelQ,
  output logic              extFallQ
);
  logic runQ, modeQ, edgeSelQ, polQ;
  logic cycS1, cycS2, cycPrev;
  logic cmpFlag, capFlag, ovfFlag;
  logic wrCtrl, wrStat, pickFall, edgeHit;
  logic setCmp, setOvf;
  logic [2:0] clrBits;

  assign wrCtrl   = wrEn && (addr == A_CTRL);
  assign wrStat   = wrEn && (addr == A_STAT);
  assign clrBits  = wrStat ? wrData[2:0] : 3'b000;
  assign active   = runQ || modeQ;
  assign pickFall = edgeSelQ ^ polQ;
  assign edgeHit  = pickFall ? (!cycS2 && cycPrev) : (cycS2 && !cycPrev);
  assign setCmp   = runQ && !modeQ && cmpEq;
  assign setOvf   = modeQ && wrapEvt;

  always_comb begin
    strb.tick     = tick;
    strb.cntWr    = wrEn && (addr == A_CNT);
    strb.cmpWr    = wrEn && (addr == A_CMP);
    strb.capEvt   = edgeHit;
    strb.clrOnCap = modeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      modeQ    <= 1'b0;
      edgeSelQ <= 1'b0;
      polQ     <= 1'b0;
      extFallQ <= 1'b0;
      clkSelQ  <= '0;
      cycS1    <= 1'b0;
      cycS2    <= 1'b0;
      cycPrev  <= 1'b0;
      cmpFlag  <= 1'b0;
      capFlag  <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        runQ     <= wrData[B_RUN];
        modeQ    <= wrData[B_MEAS];
        edgeSelQ <= wrData[B_EDGE];
        polQ     <= wrData[B_POL];
        extFallQ <= wrData[B_EXTF];
        if (!runQ && !modeQ) clkSelQ <= wrData[B_SEL +: SEL_W];
      end
      cycS1   <= cycIn;
      cycS2   <= cycS1;
      cycPrev <= cycS2;
      cmpFlag <= setCmp  || (cmpFlag && !clrBits[F_CMP]);
      capFlag <= edgeHit || (capFlag && !clrBits[F_CAP]);
      ovfFlag <= setOvf  || (ovfFlag && !clrBits[F_OVF]);
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL: begin
        rdData[B_RUN]             = runQ;
        rdData[B_MEAS]            = modeQ;
        rdData[B_EDGE]            = edgeSelQ;
        rdData[B_POL]             = polQ;
        rdData[B_SEL +: SEL_W]    = clkSelQ;
        rdData[B_EXTF]            = extFallQ;
      end
      A_STAT: begin
        rdData[F_CMP] = cmpFlag;
        rdData[F_CAP] = capFlag;
        rdData[F_OVF] = ovfFlag;
      end
      A_CNT:   rdData = countQ;
      A_CMP:   rdData = compareQ;
      A_CAP:   rdData = captureQ;
      default: rdData = '0;
    endcase
  end

  // R4
  clksel_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ || modeQ) |=> $stable(clkSelQ));
  // R7
  cmp_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpFlag) |-> $past(runQ && !modeQ));
  // R9
  ovf_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(modeQ));
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && wrData[F_CAP] && !edgeHit) |=> !capFlag);
endmodule

// File: rtl/cycle_meas_timer.sv
module cycle_meas_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             cycIn,
  input  logic             extClkIn
);
  dpStrobe_t        strb;
  logic             tick, active, extFall, cmpEq, wrapEvt;
  logic [SEL_W-1:0] clkSel;
  logic [CNT_W-1:0] countQ, compareQ, captureQ;

  cmt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cycIn(cycIn), .tick(tick), .cmpEq(cmpEq), .wrapEvt(wrapEvt),
    .countQ(countQ), .compareQ(compareQ), .captureQ(captureQ),
    .strb(strb), .rdData(rdData), .active(active),
    .clkSelQ(clkSel), .extFallQ(extFall)
  );

  cmt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rstN(rstN), .active(active), .selQ(clkSel),
    .extFall(extFall), .extClkIn(extClkIn), .tick(tick)
  );

  cmt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .countQ(countQ), .compareQ(compareQ), .captureQ(captureQ),
    .cmpEq(cmpEq), .wrapEvt(wrapEvt)
  );
endmodule

// File: tb/sim_cycle_meas_timer.sv
module sim_cycle_meas_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic        cycIn = 1'b0;
  logic        extClkIn = 1'b0;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  cycle_meas_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cycIn(cycIn), .extClkIn(extClkIn)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prep();
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0007);
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(3'd1, v); chk("R1 status", v, 16'h0);
    rd(3'd2, v); chk("R1 count", v, 16'h0);
    rd(3'd3, v); chk("R1 compare", v, 16'h0);
    rd(3'd4, v); chk("R1 capture", v, 16'h0);
  endtask

  task automatic testDivisors();
    logic [15:0] v;
    for (int s = 0; s < 7; s++) begin
      int d;
      d = (s == 0) ? 2 : (1 << (s + 2));
      prep();
      wr(3'd0, 16'(16'h0001 | (s << 4)));
      waitCyc(2 * d - 1);
      rd(3'd2, v); chk($sformatf("R2 sel%0d before", s), v, 16'd1);
      waitCyc(1);
      rd(3'd2, v); chk($sformatf("R2 sel%0d after", s), v, 16'd2);
    end
    wr(3'd0, 16'h0000);
  endtask

  task automatic testExtClock();
    logic [15:0] v;
    prep();
    wr(3'd0, 16'h0071);
    for (int i = 0; i < 3; i++) begin
      extClkIn = 1'b1; waitCyc(6);
      extClkIn = 1'b0; waitCyc(6);
    end
    rd(3'd2, v); chk("R3 rising count", v, 16'd3);
    prep();
    wr(3'd0, 16'h00F1);
    extClkIn = 1'b1; waitCyc(6);
    rd(3'd2, v); chk("R3 falling ignores rise", v, 16'd0);
    extClkIn = 1'b0; waitCyc(6);
    rd(3'd2, v); chk("R3 falling count", v, 16'd1);
    wr(3'd0, 16'h0000);
  endtask

  task automatic testSelLock();
    logic [15:0] v;
    prep();
    wr(3'd0, 16'h0011);
    wr(3'd0, 16'h0051);
    rd(3'd0, v); chk("R4 locked while run", v, 16'h0011);
    wr(3'd0, 16'h0060);
    rd(3'd0, v); chk("R4 locked on stop write", v, 16'h0010);
    wr(3'd0, 16'h0060);
    rd(3'd0, v); chk("R4 loads when idle", v, 16'h0060);
    wr(3'd0, 16'h0000);
  endtask

  task automatic testCapture();
    logic [15:0] v;
    for (int c = 0; c < 4; c++) begin
      logic fallSel;
      fallSel = c[0] ^ c[1];
      prep();
      wr(3'd2, 16'(16'h1230 + c));
      wr(3'd0, 16'((c[0] << 2) | (c[1] << 3)));
      @(negedge clk); cycIn = 1'b1;
      waitCyc(2);
      rd(3'd1, v); chk($sformatf("R5 combo%0d latency", c), v, 16'h0);
      waitCyc(3);
      rd(3'd1, v); chk($sformatf("R5 combo%0d rise", c), v, fallSel ? 16'h0 : 16'h2);
      cycIn = 1'b0;
      waitCyc(5);
      rd(3'd1, v); chk($sformatf("R5 combo%0d fall", c), v, 16'h2);
      rd(3'd4, v); chk($sformatf("R6 combo%0d capture", c), v, 16'(16'h1230 + c));
      rd(3'd2, v); chk($sformatf("R6 combo%0d count kept", c), v, 16'(16'h1230 + c));
    end
  endtask

  task automatic testCompare();
    logic [15:0] v;
    prep();
    wr(3'd3, 16'd5);
    wr(3'd1, 16'h0007);
    wr(3'd0, 16'h0011);
    waitCyc(38);
    rd(3'd1, v); chk("R7 before match", v & 16'h1, 16'h0);
    waitCyc(5);
    rd(3'd1, v); chk("R7 after match", v & 16'h1, 16'h1);
    wr(3'd0, 16'h0000);
  endtask

  task automatic measure(input int sel, input int period, input logic [15:0] exp);
    logic [15:0] v;
    prep();
    wr(3'd0, 16'(16'h0002 | (sel << 4)));
    @(negedge clk); cycIn = 1'b1;
    waitCyc(period / 2); cycIn = 1'b0;
    waitCyc(period / 2); cycIn = 1'b1;
    waitCyc(5);
    rd(3'd4, v); chk($sformatf("R8 period %0d", period), v, exp);
    rd(3'd1, v); chk("R8 capture flag", v & 16'h2, 16'h2);
    rd(3'd2, v); chk("R8 restarted", 16'(v < 16'd4), 16'h1);
    cycIn = 1'b0;
    wr(3'd0, 16'h0000);
  endtask

  task automatic testOverflow();
    logic [15:0] v;
    prep();
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'hFFFE);
    waitCyc(10);
    rd(3'd1, v); chk("R9 timer wrap no flag", v & 16'h4, 16'h0);
    prep();
    wr(3'd0, 16'h0002);
    wr(3'd2, 16'hFFFE);
    rd(3'd1, v); chk("R9 not yet", v & 16'h4, 16'h0);
    waitCyc(10);
    rd(3'd1, v); chk("R9 overflow", v & 16'h4, 16'h4);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R10 zero write keeps", v & 16'h4, 16'h4);
    wr(3'd1, 16'h0004);
    rd(3'd1, v); chk("R10 one write clears", v & 16'h4, 16'h0);
    wr(3'd0, 16'h0000);
  endtask

  task automatic testLoad();
    logic [15:0] v;
    prep();
    wr(3'd0, 16'h0001);
    waitCyc(7);
    wr(3'd2, 16'h4000);
    rd(3'd2, v); chk("R11 load while counting", 16'(v <= 16'h4001 && v >= 16'h4000), 16'h1);
    wr(3'd0, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testDivisors();
    testExtClock();
    testSelLock();
    testCapture();
    testCompare();
    measure(0, 40, 16'd20);
    measure(1, 64, 16'd8);
    testOverflow();
    testLoad();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule